// File: doc/BRIEF.md
# Grouped Interrupt Priority Encoder

This block gathers interrupt requests from three groups (critical, main and peripheral), filters main and peripheral requests through per-source disable masks, and presents one encoded status word. The word names the pending source that wins in each group. A request in the critical group outranks one in the main group, and a main request outranks a peripheral one. Software reads the word to decide which handler to run.

A peripheral source can be promoted to the critical or the main level. A promoted request then shows in that group's field as a reserved code, and the peripheral field carries the number of the promoted source. Peripheral source 0 is a cascade: it is asserted while any enabled bit of a 16-entry DMA-task pending register is set. A separate register reports the lowest such task.

Registers are reached through a simple word-addressed read/write port. Raw requests are level inputs that are sampled once per clock. The task pending bits are set by one-cycle pulses.

Top module: `grp_irq_encoder`

## Requirements
- R1: After reset the main mask reads 0x00010fff, the peripheral mask 0xffff_fc00 masked to 0x7ffffc00 (source 0 enabled), the task mask 0x0000ffff, both boost registers 0, the task pending register 0 and the status word 0. Addresses: 0 status, 1 main mask, 2 peripheral mask, 3 high boost, 4 medium boost, 5 task mask, 6 task pending, 7 task id.
- R2: The status word carries the critical valid flag at bit 10 with code at 9:8, the main valid flag at bit 21 with code at 20:16, and the peripheral valid flag at bit 29 with code at 28:24. A field whose flag is 0 reads all zero, and with nothing pending the word is 0. Each field reports the lowest pending code of its group.
- R3: The critical inputs crit_req_i[0], [1] and [2] report codes 0, 1 and 3. Critical inputs have no mask.
- R4: Main source n (0 or 5..16) is disabled by main mask bit 16-n set to 1. main_req_i bits 1..4 have no effect.
- R5: Peripheral source n (1..21) is driven by per_req_i[n-1] and disabled by peripheral mask bit 31-n set to 1.
- R6: High boost bit n promotes peripheral n to critical code 2, and medium boost bit n (unless high is also set) promotes it to main code 4. The peripheral field shows the lowest high-boosted pending source if the critical code is 2, else the lowest medium-boosted one if the main code is 4, else the lowest non-boosted one.
- R7: task_req_i bit n sets task pending bit n. Writing 1 to bit n at address 6 clears it. A set and a clear of the same bit in the same cycle leave it set.
- R8: Peripheral source 0 is pending when any task pending bit is set with task mask bit n at 0 (bit n = 1 disables), unless peripheral mask bit 31 is set. The task id register has bit 4 = any such bit and bits 3:0 = the lowest such task.
- R9: rdata_o loads the addressed register at the clock edge where rd_en_i is 1 and holds otherwise. A request appears in the status word read at the second edge after it is applied.
- R10: Mask and boost bits that do not exist read 0. These are main mask bits 31:17 and 15:12, peripheral mask bits 9:0, and boost bits 31:22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 3 | Critical group requests |
| main_req_i | input | 17 | Main group requests, bit n = source n |
| per_req_i | input | 21 | Peripheral requests, bit n-1 = source n |
| task_req_i | input | 16 | DMA-task pending set pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
A wrong sampled request, mask or boost bit shows up in the status word read at the very next read strobe. It appears as a wrong code in one field or as a wrong valid flag. A wrong task pending bit shows in the task id register, in the peripheral code 0, and in the pending register itself on the next read. A fault in the selection between the three peripheral sets appears only when boosts are active. For that reason random boosts are mixed with sparse random requests.

// File: rtl/gie_pkg.sv
package gie_pkg;
  localparam int NUM_CRIT = 3;
  localparam int NUM_MAIN = 17;
  localparam int NUM_PER  = 22;
  localparam int NUM_TASK = 16;
  localparam int TASK_IW  = $clog2(NUM_TASK);
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;

  localparam int MAIN_MSB = 16;  // mask bit = MAIN_MSB - n
  localparam int PER_MSB  = 31;  // mask bit = PER_MSB - n
  localparam int MAIN_BOOST_CODE = 4;
  localparam int CRIT_BOOST_CODE = 2;

  localparam logic [DATA_W-1:0] MAIN_IMPL  = 32'h0001_0fff;
  localparam logic [DATA_W-1:0] PER_IMPL   = 32'hffff_fc00;
  localparam logic [DATA_W-1:0] MAIN_RST   = 32'h0001_0fff;
  localparam logic [DATA_W-1:0] PER_RST    = 32'h7fff_fc00;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_MMASK  = 3'd1,
    A_PMASK  = 3'd2,
    A_BHI    = 3'd3,
    A_BMID   = 3'd4,
    A_TMASK  = 3'd5,
    A_TPEND  = 3'd6,
    A_TASKID = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gie_pick_lowest.sv
module gie_pick_lowest #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  always_comb begin
    if (valid_o) begin
      AST_PICK_HIT: assert (vec_i[idx_o]);  // R2
      AST_PICK_LOWEST: assert ((vec_i & (({{(W-1){1'b0}}, 1'b1} << idx_o) - 1'b1)) == '0);  // R2
    end
  end
endmodule

// File: rtl/gie_task_cascade.sv
module gie_task_cascade
  import gie_pkg::*;
#(
  parameter int NT = NUM_TASK,
  parameter int IW = $clog2(NT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NT-1:0] set_i,
  input  logic [NT-1:0] clr_i,
  input  logic          mask_we_i,
  input  logic [NT-1:0] mask_d_i,
  output logic [NT-1:0] pend_o,
  output logic [NT-1:0] mask_o,
  output logic          any_o,
  output logic [IW-1:0] id_o
);
  logic [NT-1:0] pend_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;  // set wins
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  gie_pick_lowest #(.W(NT), .IW(IW)) u_pick (
    .vec_i  (pend_q & ~mask_q),
    .valid_o(any_o),
    .idx_o  (id_o)
  );

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  AST_TASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));  // R7
  AST_TASK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));  // R7
  AST_TASK_ID_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (pend_q[id_o] && !mask_q[id_o]));  // R8
endmodule

// File: rtl/gie_status_build.sv
module gie_status_build
  import gie_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CRIT-1:0] crit_pend_i,
  input  logic [NUM_MAIN-1:0] main_pend_i,
  input  logic [NUM_PER-1:0]  per_pend_i,
  input  logic [NUM_PER-1:0]  boost_hi_i,
  input  logic [NUM_PER-1:0]  boost_mid_i,
  output logic [DATA_W-1:0]   status_o
);
  localparam int MIW = $clog2(NUM_MAIN);
  localparam int PIW = $clog2(NUM_PER);

  logic [2:0][NUM_PER-1:0] per_set;
  logic [2:0]              set_any;
  logic [2:0][PIW-1:0]     set_idx;

  assign per_set[0] = per_pend_i & boost_hi_i;
  assign per_set[1] = per_pend_i & boost_mid_i & ~boost_hi_i;
  assign per_set[2] = per_pend_i & ~boost_hi_i & ~boost_mid_i;

  for (genvar g = 0; g < 3; g++) begin : g_per_lvl
    gie_pick_lowest #(.W(NUM_PER), .IW(PIW)) u_pick (
      .vec_i  (per_set[g]),
      .valid_o(set_any[g]),
      .idx_o  (set_idx[g])
    );
  end

  logic [3:0] crit_codes;
  logic       c_v;
  logic [1:0] c_idx;
  assign crit_codes = {crit_pend_i[2], set_any[0], crit_pend_i[1], crit_pend_i[0]};

  gie_pick_lowest #(.W(4), .IW(2)) u_crit (
    .vec_i(crit_codes), .valid_o(c_v), .idx_o(c_idx)
  );

  logic [NUM_MAIN-1:0] main_codes;
  logic                m_v;
  logic [MIW-1:0]      m_idx;
  always_comb begin
    main_codes = main_pend_i;
    main_codes[MAIN_BOOST_CODE] = set_any[1];
  end

  gie_pick_lowest #(.W(NUM_MAIN), .IW(MIW)) u_main (
    .vec_i(main_codes), .valid_o(m_v), .idx_o(m_idx)
  );

  logic [1:0] per_sel;
  always_comb begin
    if (c_v && c_idx == 2'(CRIT_BOOST_CODE))      per_sel = 2'd0;
    else if (m_v && m_idx == MIW'(MAIN_BOOST_CODE)) per_sel = 2'd1;
    else                                            per_sel = 2'd2;
  end

  always_comb begin
    status_o = '0;
    if (c_v) begin
      status_o[10]  = 1'b1;
      status_o[9:8] = c_idx;
    end
    if (m_v) begin
      status_o[21]    = 1'b1;
      status_o[20:16] = 5'(m_idx);
    end
    if (set_any[per_sel]) begin
      status_o[29]    = 1'b1;
      status_o[28:24] = 5'(set_idx[per_sel]);
    end
  end

  AST_BOOST_LINK_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[10] && status_o[9:8] == 2'd2) |-> status_o[29]);  // R6
  AST_BOOST_LINK_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[21] && status_o[20:16] == 5'd4) |-> status_o[29]);  // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_pend_i == '0 && main_pend_i == '0 && per_pend_i == '0) |-> (status_o == '0));  // R2
endmodule

// File: rtl/grp_irq_encoder.sv
module grp_irq_encoder
  import gie_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CRIT-1:0] crit_req_i,
  input  logic [NUM_MAIN-1:0] main_req_i,
  input  logic [NUM_PER-2:0]  per_req_i,
  input  logic [NUM_TASK-1:0] task_req_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam logic [DATA_W-1:0] BOOST_IMPL = DATA_W'((64'd1 << NUM_PER) - 1);

  logic [NUM_CRIT-1:0] crit_q;
  logic [NUM_MAIN-1:0] main_q;
  logic [NUM_PER-2:0]  per_q;
  logic [DATA_W-1:0]   mmask_q, pmask_q, bhi_q, bmid_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_q  <= '0;
      main_q  <= '0;
      per_q   <= '0;
      mmask_q <= MAIN_RST;
      pmask_q <= PER_RST;
      bhi_q   <= '0;
      bmid_q  <= '0;
    end else begin
      crit_q <= crit_req_i;
      main_q <= main_req_i;
      per_q  <= per_req_i;
      if (wr_en_i) begin
        unique case (reg_addr_e'(addr_i))
          A_MMASK: mmask_q <= wdata_i & MAIN_IMPL;
          A_PMASK: pmask_q <= wdata_i & PER_IMPL;
          A_BHI:   bhi_q   <= wdata_i & BOOST_IMPL;
          A_BMID:  bmid_q  <= wdata_i & BOOST_IMPL;
          default: ;
        endcase
      end
    end
  end

  logic [NUM_TASK-1:0] t_pend, t_mask, t_clr;
  logic                t_any;
  logic [TASK_IW-1:0]  t_id;

  assign t_clr = (wr_en_i && reg_addr_e'(addr_i) == A_TPEND) ? wdata_i[NUM_TASK-1:0] : '0;

  gie_task_cascade #(.NT(NUM_TASK), .IW(TASK_IW)) u_task (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (task_req_i),
    .clr_i    (t_clr),
    .mask_we_i(wr_en_i && reg_addr_e'(addr_i) == A_TMASK),
    .mask_d_i (wdata_i[NUM_TASK-1:0]),
    .pend_o   (t_pend),
    .mask_o   (t_mask),
    .any_o    (t_any),
    .id_o     (t_id)
  );

  logic [NUM_MAIN-1:0] main_pend;
  logic [NUM_PER-1:0]  per_pend;

  for (genvar n = 0; n < NUM_MAIN; n++) begin : g_main
    if (n >= 1 && n <= MAIN_BOOST_CODE) begin : g_gap
      assign main_pend[n] = 1'b0;
    end else begin : g_src
      assign main_pend[n] = main_q[n] & ~mmask_q[MAIN_MSB-n];
    end
  end

  for (genvar n = 0; n < NUM_PER; n++) begin : g_per
    if (n == 0) begin : g_casc
      assign per_pend[n] = t_any & ~pmask_q[PER_MSB];
    end else begin : g_src
      assign per_pend[n] = per_q[n-1] & ~pmask_q[PER_MSB-n];
    end
  end

  logic [DATA_W-1:0] status_w;

  gie_status_build u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .crit_pend_i(crit_q),
    .main_pend_i(main_pend),
    .per_pend_i (per_pend),
    .boost_hi_i (bhi_q[NUM_PER-1:0]),
    .boost_mid_i(bmid_q[NUM_PER-1:0]),
    .status_o   (status_w)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_STATUS: rd_mux = status_w;
      A_MMASK:  rd_mux = mmask_q;
      A_PMASK:  rd_mux = pmask_q;
      A_BHI:    rd_mux = bhi_q;
      A_BMID:   rd_mux = bmid_q;
      A_TMASK:  rd_mux = DATA_W'(t_mask);
      A_TPEND:  rd_mux = DATA_W'(t_pend);
      default:  rd_mux = DATA_W'({t_any, t_id});
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));  // R9
  AST_MAIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[21] |-> !(status_w[20:16] inside {5'd1, 5'd2, 5'd3}));  // R4
  AST_CASC_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmask_q[PER_MSB] |-> !(status_w[29] && status_w[28:24] == 5'd0));  // R8
endmodule

// File: tb/grp_irq_encoder_bench.sv
module grp_irq_encoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  crit_req_i = '0;
  logic [16:0] main_req_i = '0;
  logic [20:0] per_req_i = '0;
  logic [15:0] task_req_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  grp_irq_encoder u_grp_irq_encoder (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_mask = 32'h0001_0fff, p_mask = 32'h7fff_fc00;
  logic [31:0] b_hi = 0, b_mid = 0;
  logic [15:0] t_mask = 16'hffff, t_pend = 0;

  function automatic int lowest(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] pp, hi, mid, lo, sel, mc, s;
    logic [3:0] cc;
    int ci, mi, pi;
    pp = 0;
    pp[0] = (|(t_pend & ~t_mask)) & ~p_mask[31];
    for (int n = 1; n < 22; n++) pp[n] = per_req_i[n-1] & ~p_mask[31-n];
    hi = pp & b_hi; mid = pp & b_mid & ~b_hi; lo = pp & ~b_hi & ~b_mid;
    cc = {crit_req_i[2], |hi, crit_req_i[1], crit_req_i[0]};
    ci = lowest(32'(cc));
    mc = 0;
    mc[0] = main_req_i[0] & ~m_mask[16];
    for (int n = 5; n < 17; n++) mc[n] = main_req_i[n] & ~m_mask[16-n];
    mc[4] = |mid;
    mi = lowest(mc);
    if (ci == 2) sel = hi; else if (mi == 4) sel = mid; else sel = lo;
    pi = lowest(sel);
    s = 0;
    if (ci >= 0) begin s[10] = 1; s[9:8] = 2'(ci); end
    if (mi >= 0) begin s[21] = 1; s[20:16] = 5'(mi); end
    if (pi >= 0) begin s[29] = 1; s[28:24] = 5'(pi); end
    return s;
  endfunction

  function automatic logic [31:0] exp_taskid();
    int l = lowest(32'(t_pend & ~t_mask));
    return (l < 0) ? 32'h0 : (32'h10 | 32'(l));
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); rd_en_i = 1; addr_i = a;
    @(posedge clk_i); #1; rd_en_i = 0; d = rdata_o;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1; wr_en_i = 0;
    case (a)
      3'd1: m_mask = d & 32'h0001_0fff;
      3'd2: p_mask = d & 32'hffff_fc00;
      3'd3: b_hi = d & 32'h003f_ffff;
      3'd4: b_mid = d & 32'h003f_ffff;
      3'd5: t_mask = d[15:0];
      3'd6: t_pend = t_pend & ~d[15:0];
      default: ;
    endcase
  endtask

  task automatic apply(logic [2:0] c, logic [16:0] m, logic [20:0] p);
    @(negedge clk_i); crit_req_i = c; main_req_i = m; per_req_i = p;
    @(posedge clk_i); #1;
  endtask

  task automatic task_cycle(logic [15:0] s, logic [15:0] c);
    @(negedge clk_i); task_req_i = s; wr_en_i = (c != 0); addr_i = 3'd6; wdata_i = 32'(c);
    @(posedge clk_i); #1; task_req_i = 0; wr_en_i = 0;
    t_pend = (t_pend & ~c) | s;
  endtask

  task automatic chk_status(string req);
    logic [31:0] d;
    rd(3'd0, d); check(req, d, exp_status());
  endtask

  task automatic chk_task(string req);
    logic [31:0] d;
    rd(3'd7, d); check(req, d, exp_taskid());
    rd(3'd6, d); check(req, d, 32'(t_pend));
  endtask

  initial begin
    logic [31:0] d, held;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset values
    rd(3'd1, d); check("R1 main mask", d, 32'h0001_0fff);
    rd(3'd2, d); check("R1 per mask", d, 32'h7fff_fc00);
    rd(3'd5, d); check("R1 task mask", d, 32'h0000_ffff);
    rd(3'd3, d); check("R1 boost hi", d, 0);
    rd(3'd4, d); check("R1 boost mid", d, 0);
    rd(3'd6, d); check("R1 task pend", d, 0);
    rd(3'd0, d); check("R1 status", d, 0);

    // R10 unimplemented bits
    wr(3'd1, 32'hffff_ffff); rd(3'd1, d); check("R10 main mask", d, 32'h0001_0fff);
    wr(3'd2, 32'hffff_ffff); rd(3'd2, d); check("R10 per mask", d, 32'hffff_fc00);
    wr(3'd3, 32'hffff_ffff); rd(3'd3, d); check("R10 boost", d, 32'h003f_ffff);
    wr(3'd3, 0);

    // R4/R5 masked sources give nothing
    apply(3'b000, 17'h1ffff, 21'h1fffff);
    chk_status("R4 R5 all masked");

    // R3 critical codes and priority
    apply(3'b100, 0, 0); chk_status("R3 crit code 3");
    apply(3'b110, 0, 0); chk_status("R3 crit lowest code 1");
    apply(3'b101, 0, 0); chk_status("R3 crit code 0");

    // R4 main enable and gap
    wr(3'd1, 32'h0000_0000);
    apply(0, 17'h0001e, 0); chk_status("R4 main 1..4 no effect");
    apply(0, 17'h00120, 0); chk_status("R4 main lowest 5");
    apply(3'b001, 17'h00001, 0); chk_status("R2 crit and main both");

    // R5 peripheral
    wr(3'd2, 32'h0000_0000);
    apply(0, 0, 21'h000100); chk_status("R5 per source 9");
    wr(3'd2, 32'h0040_0000);
    chk_status("R5 per source 9 masked");
    apply(0, 17'h01000, 21'h100001); chk_status("R2 main over per");

    // R6 boosts
    wr(3'd3, 32'h0020_0000); wr(3'd4, 32'h0000_0004);
    apply(3'b100, 17'h00040, 21'h100003); chk_status("R6 hi boost code 2");
    apply(0, 17'h00040, 21'h000003); chk_status("R6 mid boost code 4");
    apply(0, 17'h00001, 21'h000003); chk_status("R6 main 0 beats mid boost");
    wr(3'd3, 32'h0000_0004);
    chk_status("R6 hi over mid same source");
    wr(3'd3, 0); wr(3'd4, 0);

    // R7/R8 task cascade
    apply(0, 0, 0);
    task_cycle(16'h0a00, 0); chk_task("R7 set");
    chk_status("R8 cascade masked by task mask");
    wr(3'd5, 16'hf7ff); chk_task("R8 id 11");
    chk_status("R8 cascade source 0");
    task_cycle(16'h0800, 16'h0800); chk_task("R7 set wins over clear");
    task_cycle(0, 16'h0800); chk_task("R7 W1C");
    wr(3'd5, 16'h0000); chk_task("R8 id 9");
    wr(3'd2, 32'h8000_0000); chk_status("R8 source 0 masked");
    wr(3'd2, 0); wr(3'd6, 32'hffff_ffff); chk_task("R7 clear all");

    // R9 read timing and hold
    apply(3'b010, 0, 0);
    rd(3'd0, held); check("R9 two-edge latency", held, exp_status());
    apply(3'b000, 17'h00100, 21'h0);
    @(posedge clk_i); #1;
    check("R9 rdata holds", rdata_o, held);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int unsigned r = $urandom;
      if (r[2:0] == 0) wr(3'(1 + ($urandom % 5)), $urandom & $urandom);
      if (r[4:3] == 0) task_cycle(16'($urandom & $urandom & $urandom), 16'($urandom & $urandom));
      apply(3'($urandom & $urandom), 17'($urandom & $urandom & $urandom),
            21'($urandom & $urandom & $urandom));
      chk_status("R2 R6 random status");
      if (r[6:5] == 0) chk_task("R8 random task");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule